// File: doc/BRIEF.md
# Filtered Event Counter Bank with Overflow Interrupt

This block holds a bank of programmable event counters for a processor core. Each counter slot has a 64-bit count register and a 64-bit event-control register. A slot advances by one when its event strobe is high, provided three conditions hold:

- the slot is implemented;
- its global inhibit bit is clear;
- the current privilege mode and virtualization state are not filtered out by inhibit flags in its event-control register.

When a count passes its all-ones value it returns to zero. The first such wrap sets a sticky overflow flag in the event-control register and raises a shared overflow interrupt request. That request stays high until software clears it.

Software reaches the registers through a single write port and a combinational read port. The write port has two views:

- **Wide view:** each register is written whole.
- **Narrow view:** each register is written as a low half and a high half. The narrow view puts the overflow and filter flags in the top bits of the high-half event register.

Event selection, register address decoding and timer-based overflow prediction are handled elsewhere.

Top module: `flt_pmu_bank`

## Requirements
- R1: An implemented, enabled, unfiltered slot whose `evt_i` bit is high at a rising edge reads one higher through `rd_cnt_o` after that edge; with the strobe low it holds its value.
- R2: Slot indices below 3, and indices whose `AVAIL_MASK` bit is 0, read 0 on `rd_cnt_o` and `rd_evt_o`, never count, and ignore writes (default mask 8'b1101_1000: slots 3, 4, 6 and 7 exist).
- R3: While `inhibit_i[k]` is high, slot k does not count.
- R4: Counting is blocked by these event-control bits in these states, and counts in all other cases: bit 62 in machine mode; bit 61 in supervisor mode with `virt_i` low; bit 60 in user mode with `virt_i` low; bit 59 in supervisor mode with `virt_i` high; bit 58 in user mode with `virt_i` high. `priv_i` is 0 for user, 1 for supervisor and 3 for machine.
- R5: With `mode64_i` high, a count of all ones that is stepped becomes zero.
- R6: With `mode64_i` low, `wr_kind_i` values 0 and 1 write `wr_data_i[31:0]` into bits 31:0 and 63:32 of the count, and values 2 and 3 do the same for the event-control register. The low half carries into the high half. With `mode64_i` high, kinds 0 and 2 write all 64 bits and kinds 1 and 3 are ignored.
- R7: A wrap while event-control bit 63 is clear sets that bit and drives `ovf_irq_o` high after the same edge. A wrap while bit 63 is already set raises no new request.
- R8: Bit 63 stays set through further counting and wraps, and is cleared only by a software write.
- R9: `ovf_irq_o` stays high until `irq_clr_i` is sampled high. A new overflow in the same cycle as the clear leaves it high.
- R10: A write to either register of a slot in the same cycle as its event strobe takes effect, and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode64_i | input | 1 | 1 = wide register view, 0 = narrow half view |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization active |
| inhibit_i | input | NUM_CTR | Global per-slot count inhibit |
| evt_i | input | NUM_CTR | Per-slot event strobe |
| wr_en_i | input | 1 | Software write strobe |
| wr_kind_i | input | 2 | 0 count low/whole, 1 count high, 2 event low/whole, 3 event high |
| wr_idx_i | input | IW | Slot written |
| wr_data_i | input | 64 | Write data |
| irq_clr_i | input | 1 | Clears the overflow request |
| rd_idx_i | input | IW | Slot read |
| rd_cnt_o | output | 64 | Count of the read slot |
| rd_evt_o | output | 64 | Event-control register of the read slot |
| ovf_irq_o | output | 1 | Sticky overflow interrupt request |

## Verification
The assertions assume that a count moves only when no software write is in flight. They also assume `priv_i` never carries the unused code 2. The bench keeps within both limits: it drives only the codes 0, 1 and 3, and it issues writes and strobes in separate cycles, except in the one case that deliberately tests the write-over-strobe priority. The filter is swept over every legal privilege code, both virtualization states and each of the five inhibit flags (plus no flag). The expected counts are computed arithmetically from that sweep.

// File: rtl/flt_pmu_pkg.sv
package flt_pmu_pkg;

    typedef enum logic [1:0] {
        WK_CNT_LO = 2'd0,
        WK_CNT_HI = 2'd1,
        WK_EVT_LO = 2'd2,
        WK_EVT_HI = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_MACH  = 2'd3
    } priv_e;

    localparam int CW       = 64;
    localparam int HW       = CW / 2;
    localparam int OVF_POS  = 63;
    localparam int MINH_POS = 62;
    localparam int SINH_POS = 61;
    localparam int UINH_POS = 60;
    localparam int VSIN_POS = 59;
    localparam int VUIN_POS = 58;

endpackage

// File: rtl/flt_pmu_filter.sv
module flt_pmu_filter
    import flt_pmu_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic [4:0] inh_i,     // {M, S, U, VS, VU}
    output logic       block_o
);
    always_comb begin
        block_o = 1'b0;
        unique case (priv_i)
            PRV_MACH:  block_o = inh_i[4];
            PRV_SUPER: block_o = virt_i ? inh_i[1] : inh_i[3];
            PRV_USER:  block_o = virt_i ? inh_i[0] : inh_i[2];
            default:   block_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/flt_pmu_slot.sv
module flt_pmu_slot
    import flt_pmu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode64_i,
    input  logic [1:0]    priv_i,
    input  logic          virt_i,
    input  logic          inhibit_i,
    input  logic          evt_i,
    input  logic          wr_hit_i,
    input  wr_kind_e      wr_kind_i,
    input  logic [CW-1:0] wr_data_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] ctl_o,
    output logic          ovf_new_o
);
    logic [CW-1:0] cnt_q, ctl_q;
    logic          blocked, step, at_top;

    flt_pmu_filter u_filt (
        .priv_i  (priv_i),
        .virt_i  (virt_i),
        .inh_i   (ctl_q[MINH_POS:VUIN_POS]),
        .block_o (blocked)
    );

    assign step      = evt_i && !inhibit_i && !blocked && !wr_hit_i;
    assign at_top    = &cnt_q;
    assign ovf_new_o = step && at_top && !ctl_q[OVF_POS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ctl_q <= '0;
        end else if (wr_hit_i) begin
            unique case (wr_kind_i)
                WK_CNT_LO: if (mode64_i) cnt_q <= wr_data_i;
                           else          cnt_q[HW-1:0] <= wr_data_i[HW-1:0];
                WK_CNT_HI: if (!mode64_i) cnt_q[CW-1:HW] <= wr_data_i[HW-1:0];
                WK_EVT_LO: if (mode64_i) ctl_q <= wr_data_i;
                           else          ctl_q[HW-1:0] <= wr_data_i[HW-1:0];
                WK_EVT_HI: if (!mode64_i) ctl_q[CW-1:HW] <= wr_data_i[HW-1:0];
                default:   ;
            endcase
        end else if (step) begin
            // low half carries into high half; both at all ones wrap together
            cnt_q <= cnt_q + 1'b1;
            if (at_top) ctl_q[OVF_POS] <= 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign ctl_o = ctl_q;
endmodule

// File: rtl/flt_pmu_bank.sv
module flt_pmu_bank
    import flt_pmu_pkg::*;
#(
    parameter int               NUM_CTR    = 8,
    parameter logic [NUM_CTR-1:0] AVAIL_MASK = 8'b1101_1000,
    localparam int              IW         = $clog2(NUM_CTR)
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode64_i,
    input  logic [1:0]         priv_i,
    input  logic               virt_i,
    input  logic [NUM_CTR-1:0] inhibit_i,
    input  logic [NUM_CTR-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_kind_i,
    input  logic [IW-1:0]      wr_idx_i,
    input  logic [63:0]        wr_data_i,
    input  logic               irq_clr_i,
    input  logic [IW-1:0]      rd_idx_i,
    output logic [63:0]        rd_cnt_o,
    output logic [63:0]        rd_evt_o,
    output logic               ovf_irq_o
);
    localparam int FIRST_PROG = 3;

    logic [NUM_CTR-1:0][CW-1:0] cnt_arr, ctl_arr;
    logic [NUM_CTR-1:0]         ovf_new, of_flags;
    logic                       irq_q;

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_slot
        if (k >= FIRST_PROG && AVAIL_MASK[k]) begin : g_real
            flt_pmu_slot u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .mode64_i  (mode64_i),
                .priv_i    (priv_i),
                .virt_i    (virt_i),
                .inhibit_i (inhibit_i[k]),
                .evt_i     (evt_i[k]),
                .wr_hit_i  (wr_en_i && (wr_idx_i == IW'(k))),
                .wr_kind_i (wr_kind_e'(wr_kind_i)),
                .wr_data_i (wr_data_i),
                .cnt_o     (cnt_arr[k]),
                .ctl_o     (ctl_arr[k]),
                .ovf_new_o (ovf_new[k])
            );
        end else begin : g_absent
            assign cnt_arr[k] = '0;
            assign ctl_arr[k] = '0;
            assign ovf_new[k] = 1'b0;
        end
        assign of_flags[k] = ctl_arr[k][OVF_POS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            irq_q <= 1'b0;
        else if (|ovf_new)     irq_q <= 1'b1;
        else if (irq_clr_i)    irq_q <= 1'b0;
    end

    assign rd_cnt_o  = cnt_arr[rd_idx_i];
    assign rd_evt_o  = ctl_arr[rd_idx_i];
    assign ovf_irq_o = irq_q;
endmodule

// File: rtl/flt_pmu_chk.sv
module flt_pmu_chk #(
    parameter int NUM_CTR = 8
)(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en_i,
    input logic [NUM_CTR-1:0]       inhibit_i,
    input logic                     irq_clr_i,
    input logic                     ovf_irq_o,
    input logic [NUM_CTR-1:0]       ovf_new,
    input logic [NUM_CTR-1:0]       of_flags,
    input logic [NUM_CTR-1:0][63:0] cnt_arr
);
    // R7: a fresh overflow raises the request after the edge
    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf_new) |=> ovf_irq_o);

    // R9: the request only drops after a clear
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_irq_o) |-> $past(irq_clr_i));

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_k
        // R1: without writes a count moves by at most one per cycle
        assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en_i |=> (cnt_arr[k] == $past(cnt_arr[k]) ||
                          cnt_arr[k] == $past(cnt_arr[k]) + 64'd1));

        // R3: a globally inhibited slot holds
        assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (inhibit_i[k] && !wr_en_i) |=> $stable(cnt_arr[k]));

        // R8: overflow flag is sticky without software writes
        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (of_flags[k] && !wr_en_i) |=> of_flags[k]);
    end
endmodule

bind flt_pmu_bank flt_pmu_chk #(.NUM_CTR(NUM_CTR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .inhibit_i (inhibit_i),
    .irq_clr_i (irq_clr_i),
    .ovf_irq_o (ovf_irq_o),
    .ovf_new   (ovf_new),
    .of_flags  (of_flags),
    .cnt_arr   (cnt_arr)
);

// File: tb/sim_flt_pmu_bank.sv
`timescale 1ns/1ps
module sim_flt_pmu_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode64 = 1'b1;
    logic [1:0]  priv = 2'd3;
    logic        virt = 1'b0;
    logic [7:0]  inhibit = '0;
    logic [7:0]  evt = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic [2:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        irq_clr = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [63:0] rd_cnt, rd_evt;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [63:0] c, e;
    localparam logic [7:0] AVAIL = 8'b1101_1000;
    localparam logic [63:0] ONES = {64{1'b1}};

    always #4 clk = ~clk;

    flt_pmu_bank u0 (
        .clk(clk), .rst_n(rst_n), .mode64_i(mode64), .priv_i(priv),
        .virt_i(virt), .inhibit_i(inhibit), .evt_i(evt), .wr_en_i(wr_en),
        .wr_kind_i(wr_kind), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .irq_clr_i(irq_clr), .rd_idx_i(rd_idx), .rd_cnt_o(rd_cnt),
        .rd_evt_o(rd_evt), .ovf_irq_o(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input int idx, input logic [63:0] d);
        wr_en = 1'b1; wr_kind = kind; wr_idx = idx[2:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic clr_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic rd(input int idx);
        rd_idx = idx[2:0];
        #1;
        c = rd_cnt;
        e = rd_evt;
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        for (int k = 0; k < 8; k++) begin
            rd(k);
            chk($sformatf("R1 reset cnt[%0d]", k), c, 64'd0);
            chk($sformatf("R1 reset evt[%0d]", k), e, 64'd0);
        end
        chk("R9 reset irq", {63'd0, irq}, 64'd0);

        // R1 / R2: several strobe patterns
        for (int n = 1; n <= 5; n++) pulse(8'hFF);
        for (int k = 0; k < 8; k++) begin
            rd(k);
            chk($sformatf("R1/R2 count after 5 strobes idx %0d", k), c,
                (k >= 3 && AVAIL[k]) ? 64'd5 : 64'd0);
        end
        pulse(8'b1000_1000);
        pulse(8'b1000_0000);
        rd(3); chk("R1 pattern idx3", c, 64'd6);
        rd(4); chk("R1 pattern idx4", c, 64'd5);
        rd(7); chk("R1 pattern idx7", c, 64'd7);

        // R2: writes to absent slots ignored
        wr(2'd0, 5, 64'h1234);
        wr(2'd2, 1, 64'h55);
        rd(5); chk("R2 absent idx5 cnt", c, 64'd0);
        rd(1); chk("R2 absent idx1 evt", e, 64'd0);

        // R3: global inhibit
        inhibit = 8'b0001_0000;
        pulse(8'hFF);
        inhibit = '0;
        rd(4); chk("R3 inhibited idx4 holds", c, 64'd5);
        rd(6); chk("R3 neighbour idx6 counts", c, 64'd6);

        // R4: exhaustive filter sweep on slot 3
        for (int pi = 0; pi < 3; pi++) begin
            for (int v = 0; v < 2; v++) begin
                for (int b = 0; b < 6; b++) begin
                    logic [1:0] p;
                    logic blk;
                    p = (pi == 2) ? 2'd3 : 2'(pi);
                    priv = p; virt = v[0];
                    wr(2'd0, 3, 64'd0);
                    wr(2'd2, 3, (b < 5) ? (64'd1 << (62 - b)) : 64'd0);
                    pulse(8'b0000_1000);
                    blk = (p == 2'd3 && b == 0) ||
                          (p == 2'd1 && v == 0 && b == 1) ||
                          (p == 2'd0 && v == 0 && b == 2) ||
                          (p == 2'd1 && v == 1 && b == 3) ||
                          (p == 2'd0 && v == 1 && b == 4);
                    rd(3);
                    chk($sformatf("R4 priv=%0d virt=%0d flag=%0d", p, v, b),
                        c, blk ? 64'd0 : 64'd1);
                end
            end
        end
        priv = 2'd3; virt = 1'b0;
        wr(2'd2, 3, 64'd0);

        // R5 / R7: wide wrap raises request
        wr(2'd0, 3, ONES);
        pulse(8'b0000_1000);
        rd(3);
        chk("R5 wide wrap to zero", c, 64'd0);
        chk("R7 overflow flag set", {63'd0, e[63]}, 64'd1);
        chk("R7 irq raised", {63'd0, irq}, 64'd1);
        @(negedge clk);
        chk("R9 irq held", {63'd0, irq}, 64'd1);
        clr_irq();
        chk("R9 irq cleared", {63'd0, irq}, 64'd0);

        // R7: second wrap with flag already set
        wr(2'd0, 3, ONES);
        pulse(8'b0000_1000);
        rd(3);
        chk("R7 no new irq when flag set", {63'd0, irq}, 64'd0);
        // R8: flag sticky through counting
        for (int n = 0; n < 4; n++) pulse(8'b0000_1000);
        rd(3);
        chk("R8 flag sticky", {63'd0, e[63]}, 64'd1);
        wr(2'd2, 3, 64'd0);
        rd(3);
        chk("R8 software clears flag", {63'd0, e[63]}, 64'd0);

        // R9: new overflow wins over clear
        wr(2'd0, 4, ONES);
        evt = 8'b0001_0000; irq_clr = 1'b1;
        @(negedge clk);
        evt = '0; irq_clr = 1'b0;
        chk("R9 overflow beats clear", {63'd0, irq}, 64'd1);
        clr_irq();

        // R6: narrow view
        wr(2'd0, 3, 64'd0);
        mode64 = 1'b0;
        wr(2'd0, 3, 64'hAAAA_BBBB_FFFF_FFFF);
        rd(3); chk("R6 low half write", c, 64'h0000_0000_FFFF_FFFF);
        wr(2'd1, 3, 64'h0000_0000_0000_0005);
        pulse(8'b0000_1000);
        rd(3); chk("R6 carry into high half", c, 64'h0000_0006_0000_0000);
        wr(2'd3, 3, 64'h4000_0000);
        rd(3); chk("R6 high-half event write", e, 64'h4000_0000_0000_0000);
        pulse(8'b0000_1000);
        rd(3); chk("R6 R4 narrow machine filter", c, 64'h0000_0006_0000_0000);
        wr(2'd3, 3, 64'd0);
        wr(2'd0, 3, 64'hFFFF_FFFF);
        wr(2'd1, 3, 64'hFFFF_FFFF);
        pulse(8'b0000_1000);
        rd(3);
        chk("R6 narrow both halves wrap", c, 64'd0);
        chk("R6 narrow flag in high half", e, 64'h8000_0000_0000_0000);
        chk("R6 narrow irq", {63'd0, irq}, 64'd1);
        clr_irq();
        mode64 = 1'b1;
        wr(2'd1, 3, 64'd7);
        wr(2'd3, 3, 64'd7);
        rd(3);
        chk("R6 wide ignores high-half count write", c, 64'd0);
        chk("R6 wide ignores high-half event write", e, 64'h8000_0000_0000_0000);

        // R10: write beats strobe
        wr_en = 1'b1; wr_kind = 2'd0; wr_idx = 3'd6; wr_data = 64'd100;
        evt = 8'b0100_0000;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(6); chk("R10 write wins over strobe", c, 64'd100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule